// File: doc/BRIEF.md
# Fair Priority Bus Arbiter

This block decides which of up to sixteen devices owns a single shared transfer resource. Every device has a 4-bit priority held in a small register bank. When several devices request together, the one with the lowest priority value wins. The owner keeps the grant for as long as it needs, whether for one transfer or a burst, and signals `done_i` when it has finished.

A fairness mode can be switched on at run time. In this mode, a device whose tenure has just ended is locked out. It cannot win again until every device that is still requesting and not locked out has been served. Once no unlocked device is requesting, all lockouts clear together and a new fairness cycle begins. With fairness off, plain fixed priority applies.

The arbiter has no data path. All of its pins are plain control and status signals with no valid/ready handshake. Because the block has no back-pressure, `done_i` is the only way to end a tenure.

Top module: `fair_prio_arbiter`

## Requirements
- R1: While `rst` is high at a clock edge, the next outputs show no grant. All lockouts clear, and the priority of device i returns to the value i.
- R2: Among the eligible requesters, the device with the lowest priority value (0 is the best) is granted. When priorities are equal, the lower device index wins.
- R3: When `cfg_we_i` is high at a clock edge, `cfg_prio_i` becomes the priority of device `cfg_idx_i`. Arbitration from the next cycle uses the new value.
- R4: An arbitration round happens only at an edge where the resource is idle or `done_i` is high. A grant decided at an edge appears on the outputs right after that edge. It then stays unchanged, whatever the request lines do, until a round ends it.
- R5: `gnt_o` is one-hot or all zero. `gnt_valid_o` is high exactly when a grant is held, and `gnt_idx_o` is the index of the granted bit.
- R6: `done_i` has no effect while nothing is granted.
- R7: With `fair_en_i` high, a device whose tenure ends is locked out. A locked-out device is never granted while any unlocked device requests.
- R8: With fairness on, all lockouts clear at any edge where no unlocked device is requesting. No grant is made at that edge. The next round arbitrates among all requesters again.
- R9: With `fair_en_i` low, lockouts are ignored and cleared. An owner that raises `done_i` while still requesting and still the best is granted again without a gap.
- R10: A device that drops its request before it is granted leaves no trace: it is neither granted nor locked out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_i | input | 16 | One request line per device |
| fair_en_i | input | 1 | Enables the fairness lockout |
| done_i | input | 1 | The current owner ends its tenure |
| cfg_we_i | input | 1 | Priority register write strobe |
| cfg_idx_i | input | 4 | Device whose priority is written |
| cfg_prio_i | input | 4 | New priority value, 0 is the best |
| gnt_o | output | 16 | One-hot grant |
| gnt_valid_o | output | 1 | A grant is held |
| gnt_idx_o | output | 4 | Index of the granted device |

## Verification
The hardest state to reach from the ports is the instant when the last unlocked requester finishes while locked-out devices are still requesting. At that edge the lockouts must clear, no grant may be issued, and device order must restart on the following round. The stimulus walks three requesters through a whole fairness cycle with successive `done_i` pulses to reach this state. It then repeats the cycle with a request that rises and falls in the middle of a tenure, which shows that the transient request is neither locked out nor granted.

// File: rtl/arb_pkg.sv
package arb_pkg;
  typedef enum logic {
    ARB_IDLE = 1'b0,
    ARB_HELD = 1'b1
  } arb_state_e;

  localparam int unsigned ARB_DEF_DEVICES = 16;
  localparam int unsigned ARB_DEF_PRIO_W  = 4;
endpackage

// File: rtl/arb_prio_regs.sv
module arb_prio_regs #(
  parameter int unsigned N_DEV  = 16,
  parameter int unsigned PRIO_W = 4,
  localparam int unsigned IDX_W = (N_DEV > 1) ? $clog2(N_DEV) : 1
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          we_i,
  input  logic [IDX_W-1:0]              widx_i,
  input  logic [PRIO_W-1:0]             wval_i,
  output logic [N_DEV-1:0][PRIO_W-1:0]  prio_o
);
  for (genvar g = 0; g < N_DEV; g++) begin : g_dev
    logic [PRIO_W-1:0] val_q;
    always_ff @(posedge clk) begin
      if (rst) begin
        val_q <= PRIO_W'(g);
      end else if (we_i && (widx_i == IDX_W'(g))) begin
        val_q <= wval_i;
      end
    end
    assign prio_o[g] = val_q;
  end
endmodule

// File: rtl/arb_pick.sv
module arb_pick #(
  parameter int unsigned N_DEV  = 16,
  parameter int unsigned PRIO_W = 4,
  localparam int unsigned IDX_W = (N_DEV > 1) ? $clog2(N_DEV) : 1
) (
  input  logic [N_DEV-1:0]              elig_i,
  input  logic [N_DEV-1:0][PRIO_W-1:0]  prio_i,
  output logic                          found_o,
  output logic [IDX_W-1:0]              win_o
);
  logic [PRIO_W-1:0] best_p;

  // Strict less-than keeps the earlier (lower) index on a tie.
  always_comb begin
    found_o = 1'b0;
    win_o   = '0;
    best_p  = '1;
    for (int i = 0; i < N_DEV; i++) begin
      if (elig_i[i] && (!found_o || (prio_i[i] < best_p))) begin
        found_o = 1'b1;
        win_o   = IDX_W'(i);
        best_p  = prio_i[i];
      end
    end
  end
endmodule

// File: rtl/arb_lockout.sv
module arb_lockout #(
  parameter int unsigned N_DEV = 16,
  localparam int unsigned IDX_W = (N_DEV > 1) ? $clog2(N_DEV) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fair_en_i,
  input  logic [N_DEV-1:0]  req_i,
  input  logic              tenure_end_i,
  input  logic [IDX_W-1:0]  owner_i,
  output logic [N_DEV-1:0]  lock_eff_o,
  output logic [N_DEV-1:0]  elig_o
);
  logic [N_DEV-1:0] lock_q, lock_d, set_mask;

  always_comb begin
    set_mask   = (fair_en_i && tenure_end_i) ?
                 ({{(N_DEV-1){1'b0}}, 1'b1} << owner_i) : '0;
    lock_eff_o = lock_q | set_mask;
    elig_o     = fair_en_i ? (req_i & ~lock_eff_o) : req_i;
    if (!fair_en_i || (elig_o == '0)) lock_d = '0;
    else                              lock_d = lock_eff_o;
  end

  always_ff @(posedge clk) begin
    if (rst) lock_q <= '0;
    else     lock_q <= lock_d;
  end

  // R9
  no_lock_off_chk: assert property (@(posedge clk) disable iff (rst)
    !fair_en_i |=> (lock_q == '0));

  // R8
  lock_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (fair_en_i && ((req_i & ~lock_eff_o) == '0)) |=> (lock_q == '0));
endmodule

// File: rtl/fair_prio_arbiter.sv
module fair_prio_arbiter #(
  parameter int unsigned N_DEV  = arb_pkg::ARB_DEF_DEVICES,
  parameter int unsigned PRIO_W = arb_pkg::ARB_DEF_PRIO_W,
  localparam int unsigned IDX_W = (N_DEV > 1) ? $clog2(N_DEV) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_DEV-1:0]  req_i,
  input  logic              fair_en_i,
  input  logic              done_i,
  input  logic              cfg_we_i,
  input  logic [IDX_W-1:0]  cfg_idx_i,
  input  logic [PRIO_W-1:0] cfg_prio_i,
  output logic [N_DEV-1:0]  gnt_o,
  output logic              gnt_valid_o,
  output logic [IDX_W-1:0]  gnt_idx_o
);
  import arb_pkg::*;

  arb_state_e st_q;
  logic [IDX_W-1:0] own_q;
  logic [N_DEV-1:0][PRIO_W-1:0] prio;
  logic [N_DEV-1:0] elig, lock_eff;
  logic found, round, tenure_end;
  logic [IDX_W-1:0] win;

  assign round      = (st_q == ARB_IDLE) || done_i;
  assign tenure_end = (st_q == ARB_HELD) && done_i;

  arb_prio_regs #(.N_DEV(N_DEV), .PRIO_W(PRIO_W)) i_regs (
    .clk(clk), .rst(rst), .we_i(cfg_we_i), .widx_i(cfg_idx_i),
    .wval_i(cfg_prio_i), .prio_o(prio)
  );

  arb_lockout #(.N_DEV(N_DEV)) i_lock (
    .clk(clk), .rst(rst), .fair_en_i(fair_en_i), .req_i(req_i),
    .tenure_end_i(tenure_end), .owner_i(own_q),
    .lock_eff_o(lock_eff), .elig_o(elig)
  );

  arb_pick #(.N_DEV(N_DEV), .PRIO_W(PRIO_W)) i_pick (
    .elig_i(elig), .prio_i(prio), .found_o(found), .win_o(win)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= ARB_IDLE;
      own_q <= '0;
    end else if (round) begin
      if (found) begin
        st_q  <= ARB_HELD;
        own_q <= win;
      end else begin
        st_q  <= ARB_IDLE;
      end
    end
  end

  assign gnt_valid_o = (st_q == ARB_HELD);
  assign gnt_idx_o   = own_q;
  assign gnt_o       = gnt_valid_o ? ({{(N_DEV-1){1'b0}}, 1'b1} << own_q) : '0;

  // R5
  gnt_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(gnt_o));

  // R4
  hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (gnt_valid_o && !done_i) |=> (gnt_valid_o && $stable(gnt_idx_o)));

  // R7
  no_locked_win_chk: assert property (@(posedge clk) disable iff (rst)
    (round && found && fair_en_i) |-> !lock_eff[win]);

  // R2
  round_grant_chk: assert property (@(posedge clk) disable iff (rst)
    (round && (elig != '0)) |=> gnt_valid_o);

  // R6
  idle_done_chk: assert property (@(posedge clk) disable iff (rst)
    (!gnt_valid_o && done_i && (req_i == '0)) |=> !gnt_valid_o);
endmodule

// File: tb/test_fair_prio_arbiter.sv
module test_fair_prio_arbiter;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] req = '0;
  logic        fair = 1'b0;
  logic        done = 1'b0;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_idx = '0;
  logic [3:0]  cfg_prio = '0;
  logic [15:0] gnt;
  logic        gnt_valid;
  logic [3:0]  gnt_idx;

  int n_run = 0;
  int n_fail = 0;
  bit ended = 1'b0;

  typedef struct {
    bit    v;
    int    idx;
    string tag;
  } exp_t;
  exp_t exp_q[$];

  always #5 clk = ~clk;

  fair_prio_arbiter i_fair_prio_arbiter (
    .clk(clk), .rst(rst), .req_i(req), .fair_en_i(fair), .done_i(done),
    .cfg_we_i(cfg_we), .cfg_idx_i(cfg_idx), .cfg_prio_i(cfg_prio),
    .gnt_o(gnt), .gnt_valid_o(gnt_valid), .gnt_idx_o(gnt_idx)
  );

  // Monitor: compares outputs mid-cycle against the queued expectation.
  always @(negedge clk) begin
    while (exp_q.size() > 0) begin
      exp_t e;
      logic [15:0] eg;
      e = exp_q.pop_front();
      eg = e.v ? (16'h1 << e.idx) : 16'h0;
      n_run++;
      if (gnt_valid !== e.v || gnt !== eg || (e.v && gnt_idx !== 4'(e.idx))) begin
        n_fail++;
        $display("FAIL %s: valid=%0b idx=%0d gnt=%h, expected valid=%0b idx=%0d gnt=%h",
                 e.tag, gnt_valid, gnt_idx, gnt, e.v, e.idx, eg);
      end
    end
  end

  // Driver: apply inputs, take one edge, queue the expected result.
  task automatic step(input logic [15:0] rq, input logic dn, input bit ev,
                      input int ei, input string tag);
    req  = rq;
    done = dn;
    @(posedge clk);
    #1;
    cfg_we = 1'b0;
    exp_q.push_back('{ev, ei, tag});
  endtask

  function automatic logic [15:0] m(input int a, input int b = -1, input int c = -1);
    logic [15:0] r = '0;
    r[a] = 1'b1;
    if (b >= 0) r[b] = 1'b1;
    if (c >= 0) r[c] = 1'b1;
    return r;
  endfunction

  initial begin
    repeat (3) @(posedge clk);
    #1;
    step('0, 0, 0, 0, "R1 no grant after reset");
    rst = 1'b0;
    step('0, 0, 0, 0, "R1 idle with no requests");
    step(m(3, 7), 0, 1, 3, "R1 default priorities: 3 beats 7");
    step(m(0, 3, 7), 0, 1, 3, "R4 grant held while requests change");
    step(m(0, 3, 7), 1, 1, 0, "R2 lowest value wins at done");
    step(m(0), 1, 1, 0, "R9 back-to-back regrant with fairness off");
    step('0, 1, 0, 0, "R4 tenure ends with no requester");
    step('0, 1, 0, 0, "R6 done while idle ignored");
    cfg_we = 1'b1; cfg_idx = 4'd5; cfg_prio = 4'd0;
    step('0, 0, 0, 0, "R3 write leaves grant untouched");
    step(m(2, 5), 0, 1, 5, "R3 rewritten priority wins");
    cfg_we = 1'b1; cfg_idx = 4'd9; cfg_prio = 4'd0;
    step(m(2, 5), 0, 1, 5, "R4 held during priority write");
    step(m(5, 9), 1, 1, 5, "R2 equal values, lower index wins");
    step(m(9), 1, 1, 9, "R3 second rewritten device");
    step('0, 1, 0, 0, "R4 release");
    fair = 1'b1;
    step(m(1, 2, 3), 0, 1, 1, "R7 first of fairness cycle");
    step(m(1, 2, 3), 1, 1, 2, "R7 served device locked out");
    step(m(1, 2, 3), 1, 1, 3, "R7 two devices locked out");
    step(m(1, 2, 3), 1, 0, 0, "R8 all locked, clear with no grant");
    step(m(1, 2, 3), 0, 1, 1, "R8 new fairness cycle restarts");
    step(m(1, 2, 3), 1, 1, 2, "R7 lockout again");
    step(m(1, 3), 0, 1, 2, "R4 burst holds after owner drops request");
    step(m(1, 3), 1, 1, 3, "R7 only unlocked requester wins");
    step(m(0, 1, 3), 0, 1, 3, "R10 transient request during tenure");
    step(m(1, 3), 1, 0, 0, "R10 dropped device not granted, cycle clears");
    step(m(1, 3), 0, 1, 1, "R10 order restarts without device 0");
    fair = 1'b0;
    step(m(1, 3), 1, 1, 1, "R9 lockouts ignored with fairness off");
    step('0, 1, 0, 0, "R9 release");
    rst = 1'b1;
    step(m(1), 0, 0, 0, "R1 reset blocks grant");
    rst = 1'b0;
    step(m(2, 5), 0, 1, 2, "R1 priority of 5 restored by reset");
    @(negedge clk);
    #1;
    if (!ended) begin
      ended = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!ended) begin
      ended = 1'b1;
      n_run++;
      n_fail++;
      $display("FAIL watchdog: run=%0d expected completion", n_run);
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule